// File: doc/BRIEF.md
# Bus Address Translation Windows

This block translates addresses between a host processor and a PCI-style bus. It holds a set of outbound windows, which map processor addresses onto bus addresses, and a set of inbound windows, which map bus addresses back onto local memory. Software programs each window through a 32-bit register port by writing a base page, a target page and an attribute word. The attribute word carries an enable bit and a power-of-two size code.

Two combinational lookup ports use the programmed windows. The outbound port takes a processor address. The inbound port takes a bus address. Each port returns a hit flag, the number of the window that matched, and the translated address. On a miss the address comes back unchanged.

On the inbound side, a fixed direct-mapped region at the bottom of the bus address space has priority over every inbound window. A spare timer register can be written and read back, but it has no effect on translation.

Top module: `atw_xlate`

## Requirements
- R1: After reset every register reads as zero. Every window is therefore disabled, and both lookup ports report a miss.
- R2: Outbound window n (1..OB_N) occupies register offset 0xC00 + 0x20*n. Within it, the target page is at +0x00, an extended target word at +0x04, the base page at +0x08 and the attribute word at +0x10. All four read back what was written.
- R3: Inbound window k (0..IB_N-1) occupies offset 0xDA0 + 0x20*k. Within it, the target page is at +0x00, the base page at +0x08, an extended base word at +0x0C and the attribute word at +0x10. All four read back what was written.
- R4: Any other offset reads as zero, and a write to it changes no register and no lookup result. This includes outbound +0x0C, inbound +0x04 and offset 0x000.
- R5: The timer register at offset 0xE20 stores a written word and returns it on a read. It does not change any lookup result.
- R6: Attribute bit 31 enables a window. A window whose enable bit is clear never matches.
- R7: An enabled window matches address a when base <= a < base + size. Here base is the base page shifted left by 12, and size is 2 << attr[5:0] bytes. The upper bound is exclusive.
- R8: The translated address is target + (a - base), taken modulo 2^ADDR_W. Here target is the target page shifted left by 12.
- R9: When several windows on the same port match, the lowest-numbered window wins. `ob_win` reports its number n, and `ib_win` reports its index k.
- R10: When no window matches, the hit flag is 0, the window number is 0, and the translated address equals the input address.
- R11: An inbound address below DIRECT_SIZE takes the direct path. In that case `ib_direct` is 1, `ib_hit` is 0 and the address passes through unchanged, even where an inbound window covers it.
- R12: A register write changes the lookup result in the clock cycle that follows the write edge. The old mapping stops applying at the same moment.
- R13: A read returns its data on `reg_rdata` after the clock edge at which `reg_rd` is sampled high. `reg_rdata` holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the register in the 4 KiB space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ob_addr | input | ADDR_W | Processor address to translate outbound |
| ob_hit | output | 1 | An outbound window matched |
| ob_win | output | 3 | Number of the winning outbound window, 0 on a miss |
| ob_xaddr | output | ADDR_W | Outbound translated address |
| ib_addr | input | ADDR_W | Bus address to translate inbound |
| ib_hit | output | 1 | An inbound window matched and the direct path did not claim the address |
| ib_direct | output | 1 | The address lies in the direct region |
| ib_win | output | 2 | Index of the winning inbound window, 0 on a miss |
| ib_xaddr | output | ADDR_W | Inbound translated address |

## Verification
The bench builds the block with ADDR_W = 32, four outbound windows, three inbound windows and a direct region of 256 MiB. With 32-bit addresses, a window that ends exactly on the top of the address space and a target near the top are both within reach. With four outbound slots, overlapping pairs, a disabled slot and a slot enabled late can all be exercised. The 256 MiB direct region is large enough that an inbound window placed inside it can be shown to lose to the direct path, while windows above it still translate.

// File: rtl/atw_pkg.sv
package atw_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned ROFF_W    = 12;
   localparam int unsigned SLOT_W    = 5;
   localparam int unsigned PAGE_SH   = 12;
   localparam int unsigned SZ_W      = 6;
   localparam int unsigned EN_BIT    = 31;

   localparam logic [ROFF_W-1:0] OB_ORIGIN = 12'hC00;
   localparam logic [ROFF_W-1:0] IB_ORIGIN = 12'hDA0;
   localparam logic [ROFF_W-1:0] TMR_OFF   = 12'hE20;
   localparam int unsigned       SLOT_STEP = 32;

   localparam logic [SLOT_W-1:0] S_TGT   = 5'h00;
   localparam logic [SLOT_W-1:0] S_OBEXT = 5'h04;
   localparam logic [SLOT_W-1:0] S_BASE  = 5'h08;
   localparam logic [SLOT_W-1:0] S_IBEXT = 5'h0C;
   localparam logic [SLOT_W-1:0] S_ATTR  = 5'h10;

   typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/atw_win_match.sv
module atw_win_match #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic                      en,
   input  logic [atw_pkg::SZ_W-1:0]  sz,
   input  atw_pkg::word_t            base_pg,
   input  atw_pkg::word_t            tgt_pg,
   input  logic [ADDR_W-1:0]         addr,
   output logic                      hit,
   output logic [ADDR_W-1:0]         xaddr
);
   localparam int unsigned CW  = 66;
   localparam int unsigned PADW = CW - atw_pkg::WORD_W - atw_pkg::PAGE_SH;

   logic [CW-1:0] a_w, lo_w, hi_w, tg_w, sum_w;

   always_comb begin
      a_w   = CW'(addr);
      lo_w  = {{PADW{1'b0}}, base_pg, {atw_pkg::PAGE_SH{1'b0}}};
      tg_w  = {{PADW{1'b0}}, tgt_pg,  {atw_pkg::PAGE_SH{1'b0}}};
      hi_w  = lo_w + (CW'(2) << sz);
      sum_w = tg_w + (a_w - lo_w);
      hit   = en && (a_w >= lo_w) && (a_w < hi_w);
      xaddr = sum_w[ADDR_W-1:0];
   end
endmodule

// File: rtl/atw_win_slot.sv
module atw_win_slot #(
   parameter int unsigned ADDR_W = 32,
   parameter logic [atw_pkg::SLOT_W-1:0] EXT_OFF = atw_pkg::S_OBEXT
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr,
   input  logic                        sel,
   input  logic [atw_pkg::SLOT_W-1:0]  sub,
   input  atw_pkg::word_t              wdata,
   output atw_pkg::word_t              rdata,
   input  logic [ADDR_W-1:0]           addr,
   output logic                        hit,
   output logic [ADDR_W-1:0]           xaddr
);
   import atw_pkg::*;

   word_t tgt_q, ext_q, base_q, attr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q  <= '0;
         ext_q  <= '0;
         base_q <= '0;
         attr_q <= '0;
      end else if (wr && sel) begin
         if (sub == S_TGT)   tgt_q  <= wdata;
         if (sub == EXT_OFF) ext_q  <= wdata;
         if (sub == S_BASE)  base_q <= wdata;
         if (sub == S_ATTR)  attr_q <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (sel) begin
         if (sub == S_TGT)   rdata = tgt_q;
         if (sub == EXT_OFF) rdata = ext_q;
         if (sub == S_BASE)  rdata = base_q;
         if (sub == S_ATTR)  rdata = attr_q;
      end
   end

   atw_win_match #(.ADDR_W(ADDR_W)) u_match (
      .en      (attr_q[EN_BIT]),
      .sz      (attr_q[SZ_W-1:0]),
      .base_pg (base_q),
      .tgt_pg  (tgt_q),
      .addr    (addr),
      .hit     (hit),
      .xaddr   (xaddr)
   );
endmodule

// File: rtl/atw_first_hit.sv
module atw_first_hit #(
   parameter int unsigned N  = 4,
   parameter int unsigned W  = 32,
   parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  hit_v,
   input  logic [W-1:0]  xa [N],
   input  logic [W-1:0]  pass,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [W-1:0]  xaddr
);
   always_comb begin
      any   = 1'b0;
      idx   = '0;
      xaddr = pass;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_v[i]) begin
            any   = 1'b1;
            idx   = IW'(i);
            xaddr = xa[i];
         end
      end
   end
endmodule

// File: rtl/atw_xlate.sv
module atw_xlate #(
   parameter int unsigned     ADDR_W      = 32,
   parameter int unsigned     OB_N        = 4,
   parameter int unsigned     IB_N        = 3,
   parameter longint unsigned DIRECT_SIZE = 64'h1000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [11:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [ADDR_W-1:0] ob_addr,
   output logic              ob_hit,
   output logic [2:0]        ob_win,
   output logic [ADDR_W-1:0] ob_xaddr,
   input  logic [ADDR_W-1:0] ib_addr,
   output logic              ib_hit,
   output logic              ib_direct,
   output logic [1:0]        ib_win,
   output logic [ADDR_W-1:0] ib_xaddr
);
   import atw_pkg::*;

   localparam int unsigned OB_IW = (OB_N > 1) ? $clog2(OB_N) : 1;
   localparam int unsigned IB_IW = (IB_N > 1) ? $clog2(IB_N) : 1;

   if (ADDR_W < 13 || ADDR_W > 64) begin : g_bad_aw
      $error("ADDR_W must lie in 13..64");
   end
   if (OB_N < 1 || OB_N > 7) begin : g_bad_ob
      $error("OB_N must lie in 1..7");
   end
   if (IB_N < 1 || IB_N > 3) begin : g_bad_ib
      $error("IB_N must lie in 1..3");
   end

   logic [ROFF_W-1:0] slot_off;
   logic [SLOT_W-1:0] sub;
   assign slot_off = {reg_addr[ROFF_W-1:SLOT_W], {SLOT_W{1'b0}}};
   assign sub      = reg_addr[SLOT_W-1:0];

   word_t             ob_rdv [OB_N];
   word_t             ib_rdv [IB_N];
   logic [OB_N-1:0]   ob_hv;
   logic [IB_N-1:0]   ib_hv;
   logic [ADDR_W-1:0] ob_xa [OB_N];
   logic [ADDR_W-1:0] ib_xa [IB_N];

   for (genvar i = 0; i < OB_N; i++) begin : g_ob
      logic sel;
      assign sel = (slot_off == OB_ORIGIN + ROFF_W'((i + 1) * SLOT_STEP));
      atw_win_slot #(.ADDR_W(ADDR_W), .EXT_OFF(S_OBEXT)) u_slot (
         .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(sel), .sub(sub),
         .wdata(reg_wdata), .rdata(ob_rdv[i]),
         .addr(ob_addr), .hit(ob_hv[i]), .xaddr(ob_xa[i])
      );
   end

   for (genvar k = 0; k < IB_N; k++) begin : g_ib
      logic sel;
      assign sel = (slot_off == IB_ORIGIN + ROFF_W'(k * SLOT_STEP));
      atw_win_slot #(.ADDR_W(ADDR_W), .EXT_OFF(S_IBEXT)) u_slot (
         .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(sel), .sub(sub),
         .wdata(reg_wdata), .rdata(ib_rdv[k]),
         .addr(ib_addr), .hit(ib_hv[k]), .xaddr(ib_xa[k])
      );
   end

   // Spare timer word: storage only.
   word_t tmr_q;
   logic  tmr_sel;
   assign tmr_sel = (reg_addr == TMR_OFF);

   always_ff @(posedge clk) begin
      if (!rst_n)                tmr_q <= '0;
      else if (reg_wr && tmr_sel) tmr_q <= reg_wdata;
   end

   word_t rd_val;
   always_comb begin
      rd_val = tmr_sel ? tmr_q : '0;
      for (int i = 0; i < OB_N; i++) rd_val = rd_val | ob_rdv[i];
      for (int k = 0; k < IB_N; k++) rd_val = rd_val | ib_rdv[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_val;
   end

   // Outbound priority selection
   logic             ob_any;
   logic [OB_IW-1:0] ob_idx;
   atw_first_hit #(.N(OB_N), .W(ADDR_W), .IW(OB_IW)) u_ob_pick (
      .hit_v(ob_hv), .xa(ob_xa), .pass(ob_addr),
      .any(ob_any), .idx(ob_idx), .xaddr(ob_xaddr)
   );
   assign ob_hit = ob_any;
   assign ob_win = ob_any ? (3'(ob_idx) + 3'd1) : 3'd0;

   // Inbound priority selection, then direct-region override
   logic             ib_any;
   logic [IB_IW-1:0] ib_idx;
   logic [ADDR_W-1:0] ib_pick;
   atw_first_hit #(.N(IB_N), .W(ADDR_W), .IW(IB_IW)) u_ib_pick (
      .hit_v(ib_hv), .xa(ib_xa), .pass(ib_addr),
      .any(ib_any), .idx(ib_idx), .xaddr(ib_pick)
   );
   assign ib_direct = (64'(ib_addr) < DIRECT_SIZE);
   assign ib_hit    = ib_any && !ib_direct;
   assign ib_xaddr  = ib_hit ? ib_pick : ib_addr;
   assign ib_win    = ib_hit ? 2'(ib_idx) : 2'd0;
endmodule

// File: rtl/atw_xlate_chk.sv
module atw_xlate_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OB_N   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_rd,
   input logic [11:0]       reg_addr,
   input logic [31:0]       reg_rdata,
   input logic [ADDR_W-1:0] ob_addr,
   input logic              ob_hit,
   input logic [2:0]        ob_win,
   input logic [ADDR_W-1:0] ob_xaddr,
   input logic [ADDR_W-1:0] ib_addr,
   input logic              ib_hit,
   input logic              ib_direct,
   input logic [ADDR_W-1:0] ib_xaddr
);
   a_r10_ob_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !ob_hit |-> (ob_xaddr == ob_addr && ob_win == 3'd0));

   a_r10_ib_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !ib_hit |-> (ib_xaddr == ib_addr));

   a_r11_direct_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ib_direct |-> !ib_hit);

   a_r9_ob_win_range: assert property (@(posedge clk) disable iff (!rst_n)
      ob_hit |-> (ob_win != 3'd0 && 32'(ob_win) <= OB_N));

   a_r4_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 12'h000) |=> (reg_rdata == 32'd0));

   a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));
endmodule

bind atw_xlate atw_xlate_chk #(.ADDR_W(ADDR_W), .OB_N(OB_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
   .reg_rdata(reg_rdata), .ob_addr(ob_addr), .ob_hit(ob_hit),
   .ob_win(ob_win), .ob_xaddr(ob_xaddr), .ib_addr(ib_addr),
   .ib_hit(ib_hit), .ib_direct(ib_direct), .ib_xaddr(ib_xaddr)
);

// File: tb/atw_xlate_test.sv
module atw_xlate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] ob_addr = '0, ib_addr = '0;
   logic        ob_hit, ib_hit, ib_direct;
   logic [2:0]  ob_win;
   logic [1:0]  ib_win;
   logic [31:0] ob_xaddr, ib_xaddr;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   atw_xlate #(.ADDR_W(32), .OB_N(4), .IB_N(3), .DIRECT_SIZE(64'h1000_0000)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ob_addr(ob_addr), .ob_hit(ob_hit), .ob_win(ob_win), .ob_xaddr(ob_xaddr),
      .ib_addr(ib_addr), .ib_hit(ib_hit), .ib_direct(ib_direct),
      .ib_win(ib_win), .ib_xaddr(ib_xaddr)
   );

   typedef struct packed {
      logic        dir;   // 0 outbound, 1 inbound
      logic [31:0] a;
      logic        hit;
      logic [2:0]  win;
      logic [31:0] xa;
      logic        dr;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 32'h8000_0000, 1'b1, 3'd1, 32'h0000_1000, 1'b0},
      '{1'b0, 32'h8000_FFFF, 1'b1, 3'd1, 32'h0001_0FFF, 1'b0},
      '{1'b0, 32'h8000_8000, 1'b1, 3'd1, 32'h0000_9000, 1'b0},
      '{1'b0, 32'h8001_0000, 1'b1, 3'd2, 32'h2000_8000, 1'b0},
      '{1'b0, 32'h8002_7FFF, 1'b1, 3'd2, 32'h2001_FFFF, 1'b0},
      '{1'b0, 32'h8002_8000, 1'b0, 3'd0, 32'h8002_8000, 1'b0},
      '{1'b0, 32'h7FFF_FFFF, 1'b0, 3'd0, 32'h7FFF_FFFF, 1'b0},
      '{1'b0, 32'h9000_0FFF, 1'b1, 3'd3, 32'hFFFF_FFFF, 1'b0},
      '{1'b0, 32'h9000_1000, 1'b0, 3'd0, 32'h9000_1000, 1'b0},
      '{1'b0, 32'hA000_0000, 1'b0, 3'd0, 32'hA000_0000, 1'b0},
      '{1'b1, 32'h4000_0010, 1'b1, 3'd0, 32'h0010_0010, 1'b0},
      '{1'b1, 32'h4008_0000, 1'b1, 3'd0, 32'h0018_0000, 1'b0},
      '{1'b1, 32'h4010_0000, 1'b1, 3'd1, 32'h5008_0000, 1'b0},
      '{1'b1, 32'h0800_0004, 1'b0, 3'd0, 32'h0800_0004, 1'b1},
      '{1'b1, 32'h4028_0000, 1'b0, 3'd0, 32'h4028_0000, 1'b0},
      '{1'b1, 32'h3FFF_FFFF, 1'b0, 3'd0, 32'h3FFF_FFFF, 1'b0}
   };

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic look_ob(input logic [31:0] a, output logic [35:0] r);
      ob_addr = a; #1;
      r = {ob_hit, ob_win, ob_xaddr};
   endtask

   function automatic logic [11:0] obo(input int n, input int s);
      return 12'(12'hC00 + n * 32 + s);
   endfunction
   function automatic logic [11:0] ibo(input int k, input int s);
      return 12'(12'hDA0 + k * 32 + s);
   endfunction

   logic [31:0] d;
   logic [35:0] r;

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(obo(1, 16), d);
      chk(d == 0, "R1 ob1 attr after reset", 64'(d), 0);
      rd(ibo(2, 8), d);
      chk(d == 0, "R1 ib2 base after reset", 64'(d), 0);
      look_ob(32'h0000_0000, r);
      chk(r == {1'b0, 3'd0, 32'h0}, "R1 ob lookup miss after reset", 64'(r), 0);
      ib_addr = 32'h0000_0000; #1;
      chk(!ib_hit, "R1 ib lookup miss after reset", 64'(ib_hit), 0);

      // programming
      wr(obo(1, 0), 32'h0000_0001); wr(obo(1, 8), 32'h0008_0000); wr(obo(1, 16), 32'h8000_000F);
      wr(obo(2, 0), 32'h0002_0000); wr(obo(2, 8), 32'h0008_0008); wr(obo(2, 16), 32'h8000_0010);
      wr(obo(3, 0), 32'h000F_FFFF); wr(obo(3, 8), 32'h0009_0000); wr(obo(3, 16), 32'h8000_000B);
      wr(obo(4, 0), 32'h0000_0123); wr(obo(4, 8), 32'h000A_0000); wr(obo(4, 16), 32'h0000_0014);
      wr(ibo(0, 0), 32'h0000_0100); wr(ibo(0, 8), 32'h0004_0000); wr(ibo(0, 16), 32'h8000_0013);
      wr(ibo(1, 0), 32'h0005_0000); wr(ibo(1, 8), 32'h0004_0080); wr(ibo(1, 16), 32'h8000_0014);
      wr(ibo(2, 0), 32'h0003_0000); wr(ibo(2, 8), 32'h0000_8000); wr(ibo(2, 16), 32'h8000_000C);

      // vector table: R6 R7 R8 R9 R10 R11
      @(negedge clk);
      for (int v = 0; v < NV; v++) begin
         if (!VEC[v].dir) begin
            ob_addr = VEC[v].a; #1;
            chk({ob_hit, ob_win, ob_xaddr} == {VEC[v].hit, VEC[v].win, VEC[v].xa},
                $sformatf("R6 R7 R8 R9 R10 ob vector %0d", v),
                64'({ob_hit, ob_win, ob_xaddr}), 64'({VEC[v].hit, VEC[v].win, VEC[v].xa}));
         end else begin
            ib_addr = VEC[v].a; #1;
            chk({ib_direct, ib_hit, ib_win, ib_xaddr} == {VEC[v].dr, VEC[v].hit, VEC[v].win[1:0], VEC[v].xa},
                $sformatf("R7 R8 R9 R10 R11 ib vector %0d", v),
                64'({ib_direct, ib_hit, ib_win, ib_xaddr}),
                64'({VEC[v].dr, VEC[v].hit, VEC[v].win[1:0], VEC[v].xa}));
         end
      end

      // R2 R3 readback
      rd(obo(1, 8), d);
      chk(d == 32'h0008_0000, "R2 ob1 base readback", 64'(d), 64'h0008_0000);
      wr(obo(2, 4), 32'h1234_5678);
      rd(obo(2, 4), d);
      chk(d == 32'h1234_5678, "R2 ob2 extended target readback", 64'(d), 64'h1234_5678);
      wr(ibo(2, 12), 32'hCAFE_0001);
      rd(ibo(2, 12), d);
      chk(d == 32'hCAFE_0001, "R3 ib2 extended base readback", 64'(d), 64'hCAFE_0001);
      rd(ibo(1, 16), d);
      chk(d == 32'h8000_0014, "R3 ib1 attr readback", 64'(d), 64'h8000_0014);

      // R4 undefined offsets
      wr(obo(1, 12), 32'hFFFF_FFFF);
      rd(obo(1, 12), d);
      chk(d == 0, "R4 ob +0x0C reads zero", 64'(d), 0);
      wr(ibo(0, 4), 32'hFFFF_FFFF);
      rd(ibo(0, 4), d);
      chk(d == 0, "R4 ib +0x04 reads zero", 64'(d), 0);
      wr(12'h000, 32'h5555_AAAA);
      rd(12'h000, d);
      chk(d == 0, "R4 offset 0x000 reads zero", 64'(d), 0);
      rd(obo(1, 16), d);
      chk(d == 32'h8000_000F, "R4 ob1 attr untouched", 64'(d), 64'h8000_000F);
      look_ob(32'h8000_8000, r);
      chk(r == {1'b1, 3'd1, 32'h0000_9000}, "R4 lookup unchanged", 64'(r), 64'({1'b1, 3'd1, 32'h0000_9000}));

      // R5 timer
      wr(12'hE20, 32'hDEAD_BEEF);
      rd(12'hE20, d);
      chk(d == 32'hDEAD_BEEF, "R5 timer readback", 64'(d), 64'hDEAD_BEEF);
      look_ob(32'h9000_0FFF, r);
      chk(r == {1'b1, 3'd3, 32'hFFFF_FFFF}, "R5 timer no lookup effect", 64'(r), 64'({1'b1, 3'd3, 32'hFFFF_FFFF}));

      // R13 read data holds
      repeat (3) @(negedge clk);
      chk(reg_rdata == 32'hDEAD_BEEF, "R13 rdata holds without read", 64'(reg_rdata), 64'hDEAD_BEEF);

      // R12 write takes effect on the next cycle
      ob_addr = 32'hA000_0010;
      @(negedge clk);
      reg_addr = obo(4, 16); reg_wdata = 32'h8000_0014; reg_wr = 1'b1;
      #1;
      chk(!ob_hit, "R12 before write edge still miss", 64'(ob_hit), 0);
      @(negedge clk);
      reg_wr = 1'b0; #1;
      chk({ob_hit, ob_win, ob_xaddr} == {1'b1, 3'd4, 32'h0012_3010}, "R12 ob4 enabled next cycle",
          64'({ob_hit, ob_win, ob_xaddr}), 64'({1'b1, 3'd4, 32'h0012_3010}));
      wr(obo(1, 16), 32'h0000_000F);
      look_ob(32'h8000_8000, r);
      chk(r == {1'b1, 3'd2, 32'h2000_0000}, "R12 R6 ob1 disabled falls to ob2",
          64'(r), 64'({1'b1, 3'd2, 32'h2000_0000}));
      look_ob(32'h8000_0000, r);
      chk(r == {1'b0, 3'd0, 32'h8000_0000}, "R12 R10 old ob1 mapping removed",
          64'(r), 64'({1'b0, 3'd0, 32'h8000_0000}));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule